// File: doc/BRIEF.md
# Planar Color-Compare Read Unit

This unit serves processor reads from a video memory organised as four bit planes. Each read strobe carries the four plane bytes at one address. The unit stores all four bytes in plane latches, which feed the write datapath. It returns one byte to the processor. In plane mode that byte is one chosen plane. In compare mode it is an 8-bit match vector. Bit b of the vector says whether pixel b across the planes equals a 4-bit reference color, with chosen planes left out of the test.

Software programs the unit through an index/data port pair. A write to the index port selects one of four registers: reference color, plane ignore mask, plane select and mode. Writes and reads on the data port then reach the selected register. A two-state controller tracks each read. `ST_IDLE` moves to `ST_DATA` on a strobe (transition `T_ACCEPT`). `ST_DATA` stays in `ST_DATA` on a back-to-back strobe (`T_CHAIN`) and returns to `ST_IDLE` when there is no strobe (`T_DONE`). `ST_IDLE` stays in `ST_IDLE` when there is no strobe (`T_WAIT`). The controller is in `ST_DATA` exactly in the cycle that the result is valid.

Top module: `plane_compare_read`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 00h and `latch_q` is 0. The reference color, ignore mask, plane select and mode bits 3:0 are all 0. Mode bits 7:4 equal the parameter `MODE_HI_RST`, which defaults to 0.
- R2: A write with `cfg_addr`=0 loads the index from `cfg_wdata[2:0]`. A write with `cfg_addr`=1 loads the register that the index selects: 0 = reference color (bits 3:0), 1 = ignore mask (bits 3:0), 2 = plane select (bits 1:0), 3 = mode. `cfg_rdata` shows the selected register, with its unused bits read as 0. Indices 4 to 7 read 00h, and writes to them change no register.
- R3: `rd_valid` is 1 in exactly the cycle after each cycle in which `rd_stb` is 1. `rd_data` takes its new value on that same edge and holds it until the next strobe.
- R4: Every strobe loads all four plane bytes of `vram_q` into `latch_q` in either mode. Plane p occupies bits 8p+7:8p. Without a strobe, `latch_q` holds its value.
- R5: When mode bit 3 is 0, a read returns the plane byte named by plane select bits 1:0.
- R6: When mode bit 3 is 1, result bit b is 1 exactly when, for every plane p whose ignore bit is 0, bit b of plane p equals bit p of the reference color.
- R7: In compare mode, a read with all four ignore bits set returns FFh, and the plane select has no effect on the result.
- R8: A data write to the mode index changes only mode bits 3:0. Bits 7:4 keep their stored value.
- R9: A configuration write in the same cycle as a read strobe does not affect that read. The read uses the register values from before the write, and the new value applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = index port, 1 = data port |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Contents of the register selected by the index |
| rd_stb | input | 1 | Processor read strobe |
| vram_q | input | 32 | Four plane bytes from memory; plane p at bits 8p+7:8p |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| latch_q | output | 32 | Plane latch contents for the write path |

## Verification
A configuration write and a read strobe can fall in the same clock cycle. The hazard is a read that sees a half-updated mode or reference color. The bench provokes this by asserting `rd_stb` and a data-port write in one cycle, for example turning compare mode on or changing the reference color. It then requires that this read gives the plane-mode or old-reference result, and that the next read gives the new result. Around this case the bench sweeps all four plane selects, and all 256 pairs of reference color and ignore mask on random plane data, against an arithmetic model of the match rule.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int NPLANE  = 4;
    localparam int PBITS   = 8;
    localparam int IDX_W   = 3;
    localparam int SEL_W   = $clog2(NPLANE);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } rd_state_e;

    typedef enum logic [IDX_W-1:0] {
        IX_REFCOL = 3'd0,
        IX_IGNORE = 3'd1,
        IX_PLSEL  = 3'd2,
        IX_MODE   = 3'd3
    } reg_idx_e;
endpackage

// File: rtl/pcr_regs.sv
module pcr_regs
    import pcr_pkg::*;
#(
    parameter int         NP          = NPLANE,
    parameter int         DW          = PBITS,
    parameter logic [3:0] MODE_HI_RST = 4'h0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic                     cfg_addr,
    input  logic [DW-1:0]            cfg_wdata,
    output logic [DW-1:0]            cfg_rdata,
    output logic [NP-1:0]            refcol_o,
    output logic [NP-1:0]            ignore_o,
    output logic [$clog2(NP)-1:0]    plsel_o,
    output logic                     cmp_en_o
);
    localparam int SW = $clog2(NP);

    logic [IDX_W-1:0] idx_q;
    logic [NP-1:0]    refcol_q;
    logic [NP-1:0]    ignore_q;
    logic [SW-1:0]    plsel_q;
    logic [3:0]       mode_lo_q;
    logic [3:0]       mode_hi_q;
    logic             data_wr;

    assign data_wr = cfg_wr && cfg_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            refcol_q  <= '0;
            ignore_q  <= '0;
            plsel_q   <= '0;
            mode_lo_q <= '0;
            mode_hi_q <= MODE_HI_RST;
        end else begin
            if (cfg_wr && !cfg_addr)
                idx_q <= cfg_wdata[IDX_W-1:0];
            if (data_wr) begin
                unique case (idx_q)
                    IX_REFCOL: refcol_q  <= cfg_wdata[NP-1:0];
                    IX_IGNORE: ignore_q  <= cfg_wdata[NP-1:0];
                    IX_PLSEL:  plsel_q   <= cfg_wdata[SW-1:0];
                    IX_MODE:   mode_lo_q <= cfg_wdata[3:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (idx_q)
            IX_REFCOL: cfg_rdata[NP-1:0] = refcol_q;
            IX_IGNORE: cfg_rdata[NP-1:0] = ignore_q;
            IX_PLSEL:  cfg_rdata[SW-1:0] = plsel_q;
            IX_MODE:   cfg_rdata[7:0]    = {mode_hi_q, mode_lo_q};
            default:   cfg_rdata = '0;
        endcase
    end

    assign refcol_o = refcol_q;
    assign ignore_o = ignore_q;
    assign plsel_o  = plsel_q;
    assign cmp_en_o = mode_lo_q[3];

    // R8: a mode write leaves the upper nibble seen on the port unchanged
    assert_mode_hi_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx_q == IX_MODE) |=> (cfg_rdata[7:4] == $past(cfg_rdata[7:4])));

    // R2: unmapped indices read as zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q > IX_MODE) |-> (cfg_rdata == '0));
endmodule

// File: rtl/pcr_match.sv
module pcr_match
    import pcr_pkg::*;
#(
    parameter int NP = NPLANE,
    parameter int DW = PBITS
) (
    input  logic [NP*DW-1:0] planes_i,
    input  logic [NP-1:0]    refcol_i,
    input  logic [NP-1:0]    ignore_i,
    output logic [DW-1:0]    match_o
);
    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic [NP-1:0] ok;
        for (genvar p = 0; p < NP; p++) begin : g_pl
            assign ok[p] = ignore_i[p] | (planes_i[p*DW+b] == refcol_i[p]);
        end
        assign match_o[b] = &ok;
    end
endmodule

// File: rtl/pcr_latch.sv
module pcr_latch
    import pcr_pkg::*;
#(
    parameter int NP = NPLANE,
    parameter int DW = PBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NP*DW-1:0] data_i,
    output logic [NP*DW-1:0] latch_o
);
    for (genvar p = 0; p < NP; p++) begin : g_plane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                latch_o[p*DW +: DW] <= '0;
            else if (load_i)
                latch_o[p*DW +: DW] <= data_i[p*DW +: DW];
        end
    end

    // R4: every strobe captures all planes
    assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (latch_o == $past(data_i)));

    // R4: latches hold without a strobe
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(latch_o));
endmodule

// File: rtl/plane_compare_read.sv
module plane_compare_read
    import pcr_pkg::*;
#(
    parameter int         NP          = NPLANE,
    parameter int         DW          = PBITS,
    parameter logic [3:0] MODE_HI_RST = 4'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             rd_stb,
    input  logic [NP*DW-1:0] vram_q,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic [NP*DW-1:0] latch_q
);
    localparam int SW = $clog2(NP);

    logic [NP-1:0] refcol;
    logic [NP-1:0] ignore;
    logic [SW-1:0] plsel;
    logic          cmp_en;
    logic [DW-1:0] match;
    logic [DW-1:0] sel_byte;
    logic [DW-1:0] result;

    rd_state_e state_q, state_d;

    pcr_regs #(.NP(NP), .DW(DW), .MODE_HI_RST(MODE_HI_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .refcol_o  (refcol),
        .ignore_o  (ignore),
        .plsel_o   (plsel),
        .cmp_en_o  (cmp_en)
    );

    pcr_match #(.NP(NP), .DW(DW)) u_match (
        .planes_i (vram_q),
        .refcol_i (refcol),
        .ignore_i (ignore),
        .match_o  (match)
    );

    pcr_latch #(.NP(NP), .DW(DW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rd_stb),
        .data_i  (vram_q),
        .latch_o (latch_q)
    );

    always_comb begin
        sel_byte = '0;
        for (int p = 0; p < NP; p++) begin
            if (plsel == SW'(p))
                sel_byte = vram_q[p*DW +: DW];
        end
    end

    assign result = cmp_en ? match : sel_byte;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: T_ACCEPT, T_WAIT, T_CHAIN, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_stb ? ST_DATA : ST_IDLE;
            ST_DATA: state_d = rd_stb ? ST_DATA : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= result;
    end

    assign rd_valid = (state_q == ST_DATA);

    // R3: a strobe yields valid data one cycle later
    assert_valid_after_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R3: no strobe, no valid and data held
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_valid && $stable(rd_data)));

    // R7: everything ignored in compare mode gives all ones
    assert_all_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && cmp_en && (&ignore)) |=> (rd_data == '1));
endmodule

// File: tb/tb_plane_compare_read.sv
module tb_plane_compare_read;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        rd_stb = 1'b0;
    logic [31:0] vram_q = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [31:0] latch_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    plane_compare_read dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_stb(rd_stb),
        .vram_q(vram_q), .rd_valid(rd_valid), .rd_data(rd_data), .latch_q(latch_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_reg(input logic [2:0] ix, input logic [7:0] d);
        cfg(1'b0, {5'd0, ix});
        cfg(1'b1, d);
    endtask

    // Issue one read; returns after the result edge, sampled at negedge
    task automatic do_read(input logic [31:0] v);
        @(negedge clk);
        rd_stb = 1'b1; vram_q = v;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    function automatic logic [7:0] model_match(input logic [31:0] v,
                                               input logic [3:0] rc,
                                               input logic [3:0] ig);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = 1'b1;
            for (int p = 0; p < 4; p++)
                if (!ig[p] && (v[p*8+b] != rc[p])) m[b] = 1'b0;
        end
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  hold;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 data", {24'd0, rd_data}, 32'd0);
        chk("R1 latch", latch_q, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 refcol", {24'd0, cfg_rdata}, 32'd0);
        cfg(1'b0, 8'd3);
        chk("R1 mode", {24'd0, cfg_rdata}, 32'd0);

        // R2 register port
        set_reg(3'd0, 8'hFA);
        chk("R2 refcol readback", {24'd0, cfg_rdata}, 32'h0A);
        set_reg(3'd1, 8'h35);
        chk("R2 ignore readback", {24'd0, cfg_rdata}, 32'h05);
        set_reg(3'd2, 8'hFE);
        chk("R2 plsel readback", {24'd0, cfg_rdata}, 32'h02);
        set_reg(3'd6, 8'hFF);
        chk("R2 unmapped reads zero", {24'd0, cfg_rdata}, 32'h00);
        cfg(1'b0, 8'd0);
        chk("R2 refcol untouched", {24'd0, cfg_rdata}, 32'h0A);
        cfg(1'b0, 8'd1);
        chk("R2 ignore untouched", {24'd0, cfg_rdata}, 32'h05);

        // R8 mode write keeps upper nibble
        set_reg(3'd3, 8'hF7);
        chk("R8 mode upper kept", {24'd0, cfg_rdata}, 32'h07);
        set_reg(3'd3, 8'h00);

        // R5 plane mode sweep, R3 / R4 timing
        for (int s = 0; s < 4; s++) begin
            set_reg(3'd2, 8'(s));
            for (int k = 0; k < 4; k++) begin
                v = $urandom;
                do_read(v);
                chk("R3 valid", {31'd0, rd_valid}, 32'd1);
                chk("R5 plane byte", {24'd0, rd_data}, {24'd0, v[s*8 +: 8]});
                chk("R4 latch load", latch_q, v);
            end
        end
        hold = rd_data;
        v = latch_q;
        @(negedge clk);
        vram_q = ~vram_q;
        @(negedge clk);
        chk("R3 valid drops", {31'd0, rd_valid}, 32'd0);
        chk("R3 data held", {24'd0, rd_data}, {24'd0, hold});
        chk("R4 latch held", latch_q, v);

        // R6 compare sweep
        set_reg(3'd3, 8'h08);
        for (int rc = 0; rc < 16; rc++) begin
            set_reg(3'd0, 8'(rc));
            for (int ig = 0; ig < 16; ig++) begin
                set_reg(3'd1, 8'(ig));
                v = $urandom;
                do_read(v);
                chk("R6 match", {24'd0, rd_data},
                    {24'd0, model_match(v, 4'(rc), 4'(ig))});
                chk("R4 latch in compare", latch_q, v);
            end
        end

        // R7 all ignored, plane select irrelevant
        set_reg(3'd1, 8'h0F);
        do_read(32'h0000_0000);
        chk("R7 all ignored", {24'd0, rd_data}, 32'hFF);
        set_reg(3'd1, 8'h00);
        set_reg(3'd0, 8'h05);
        for (int s = 0; s < 4; s++) begin
            set_reg(3'd2, 8'(s));
            v = 32'h00FF_00FF;
            do_read(v);
            chk("R7 plsel ignored", {24'd0, rd_data}, 32'hFF);
        end

        // R9 write and strobe in the same cycle
        set_reg(3'd3, 8'h00);
        set_reg(3'd2, 8'h01);
        cfg(1'b0, 8'd3);
        v = 32'h0F0F_A5F0;
        @(negedge clk);
        rd_stb = 1'b1; vram_q = v;
        cfg_wr = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h08;
        @(negedge clk);
        rd_stb = 1'b0; cfg_wr = 1'b0;
        chk("R9 old mode used", {24'd0, rd_data}, 32'hA5);
        do_read(v);
        chk("R9 new mode next", {24'd0, rd_data}, {24'd0, model_match(v, 4'h5, 4'h0)});
        cfg(1'b0, 8'd0);
        @(negedge clk);
        rd_stb = 1'b1; vram_q = v;
        cfg_wr = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h0A;
        @(negedge clk);
        rd_stb = 1'b0; cfg_wr = 1'b0;
        chk("R9 old refcol used", {24'd0, rd_data}, {24'd0, model_match(v, 4'h5, 4'h0)});
        do_read(v);
        chk("R9 new refcol next", {24'd0, rd_data}, {24'd0, model_match(v, 4'hA, 4'h0)});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule